// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the byte-wide, two-port register front end of a classic eight-input cascadable interrupt controller. Software writes to an even port and an odd port. A step counter walks those writes through the four-word initialization sequence, and after that it routes them to the run-time commands: the mask load, the end-of-interrupt/priority command and the read/mask-mode command. The block keeps the configuration state: ready, vector base, auto end-of-interrupt, special fully-nested mode, special mask mode, the read-register select and a pending poll.

The request and in-service registers, the priority scan and input trigger sampling sit in a separate priority resolver. This block shows the resolver's request and in-service bytes on reads. It strobes the resolver when initialization restarts and when an end-of-interrupt/priority command arrives, passing that command's byte. On a poll read it takes the resolver's best eligible pin and strobes its acceptance. Unsupported operating modes are rejected, and a one-cycle error flag reports the rejection.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset the following are all 0: ready, vector base, mask, auto-EOI, fully-nested, special mask, the error flag and the poll flag. The read select points at the request register, and odd-port writes load the mask.
- R2: An even-port write with bit 4 set is the first initialization word. In the same cycle it pulses init_stb_o. From the next cycle, ready, mask, special mask mode, the read select and poll are all cleared.
- R3: A first initialization word with bit 1 (single controller) set or bit 0 (fourth word needed) clear raises err_o for exactly the next cycle. The sequence does not advance, so the next odd write loads the mask and the vector base keeps its value.
- R4: The odd-port write that follows an accepted first word sets the vector base to the byte ANDed with 0xF8.
- R5: The third initialization word is discarded. Mask, vector base and ready stay unchanged, and the step counter advances.
- R6: A fourth word with bit 0 (8086 mode) clear raises err_o for one cycle and leaves ready low. The step counter stays at the fourth word, so a retry is accepted.
- R7: An accepted fourth word sets auto-EOI from its bit 1. It sets fully-nested from its bit 4 only when IS_MASTER is 1; a slave instance keeps fully-nested at 0.
- R8: After an accepted fourth word, ready is 1 and odd-port writes load the mask, which an odd-port read returns.
- R9: Once ready, an even-port write with bits 4 and 3 clear pulses ocw2_stb_o with the byte on ocw2_data_o. An even-port write with bit 4 clear while not ready has no effect.
- R10: Once ready, an even-port write with bit 3 set (and bit 4 clear) is the read/mask command. Special mask mode takes the value of bit 5 only when bit 6 is set.
- R11: In the read/mask command, bit 1 set latches the read select from bit 0 (1 = in-service) and the poll flag from bit 2. With bit 1 clear, both keep their values.
- R12: A read at either port while poll is pending clears poll. If best_valid_i is high, the read returns 0x80 OR best_pin_i and pulses accept_stb_o with that pin. Otherwise it returns 0x00 with no strobe.
- R13: With no poll pending, an odd-port read returns the mask. An even-port read returns isr_i when the select is set and irr_i when it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe; ignored when wr_i is also high |
| addr_i | input | 1 | Port select: 0 even, 1 odd |
| wdata_i | input | DATA_W | Write byte |
| rdata_o | output | DATA_W | Read byte for the current access |
| err_o | output | 1 | One-cycle pulse after a rejected initialization word |
| ready_o | output | 1 | Initialization complete |
| vec_base_o | output | DATA_W | Vector base, low three bits zero |
| aeoi_o | output | 1 | Auto end-of-interrupt enabled |
| sfn_o | output | 1 | Special fully-nested mode enabled |
| smm_o | output | 1 | Special mask mode enabled |
| mask_o | output | DATA_W | Interrupt mask register |
| irr_i | input | DATA_W | Request register from the resolver |
| isr_i | input | DATA_W | In-service register from the resolver |
| best_valid_i | input | 1 | Resolver has an eligible request |
| best_pin_i | input | PIN_W | Resolver's highest-priority eligible pin |
| init_stb_o | output | 1 | Initialization restart strobe (resolver clears requests, lowest priority becomes 7) |
| ocw2_stb_o | output | 1 | End-of-interrupt/priority command strobe |
| ocw2_data_o | output | DATA_W | Byte of that command |
| accept_stb_o | output | 1 | Poll read accepted an interrupt |
| accept_pin_o | output | PIN_W | Pin accepted by the poll read |

## Verification
The sequencer is driven with a full initialization sequence followed by mask and register reads. Distinct request and in-service bytes show which register the read select picked. The initialization sequence is also run with bad first and fourth words, which separates a sequence that is held from one that advances. A mask load after a rejected first word exposes a counter that moved when it should not have. The read/mask command is tried with the enable bits set and clear, to show that each field is latched only under its own enable. Poll reads are made with and without an eligible request, and a plain read follows each to confirm that poll was consumed. A second instance built as a slave gets the same fourth word and must keep fully-nested mode off.

// File: rtl/pic_seq_pkg.sv
package pic_seq_pkg;
  typedef enum logic [1:0] {STEP_IDLE, STEP_ICW2, STEP_ICW3, STEP_ICW4} step_e;
  typedef enum logic [2:0] {
    CMD_NONE, CMD_ICW1, CMD_ICW2, CMD_ICW3, CMD_ICW4, CMD_MASK, CMD_OCW2, CMD_OCW3
  } cmd_e;

  // even-port command class bits
  localparam int B_INIT   = 4;
  localparam int B_OPSEL  = 3;
  // first init word
  localparam int B_NEED4  = 0;
  localparam int B_SINGLE = 1;
  // fourth init word
  localparam int B_X86    = 0;
  localparam int B_AUTO   = 1;
  localparam int B_NEST   = 4;
  // read/mask command
  localparam int B_SMEN   = 6;
  localparam int B_SMVAL  = 5;
  localparam int B_POLL   = 2;
  localparam int B_RDREG  = 1;
  localparam int B_RDSVC  = 0;
endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import pic_seq_pkg::*;
(
  input  logic  wr_i,
  input  logic  addr_i,
  input  logic  init_bit_i,
  input  logic  opsel_bit_i,
  input  step_e step_i,
  input  logic  ready_i,
  output cmd_e  cmd_o
);
  always_comb begin
    cmd_o = CMD_NONE;
    if (wr_i) begin
      if (addr_i) begin
        unique case (step_i)
          STEP_ICW2: cmd_o = CMD_ICW2;
          STEP_ICW3: cmd_o = CMD_ICW3;
          STEP_ICW4: cmd_o = CMD_ICW4;
          default:   cmd_o = CMD_MASK;
        endcase
      end else if (init_bit_i) begin
        cmd_o = CMD_ICW1;
      end else if (ready_i) begin
        cmd_o = opsel_bit_i ? CMD_OCW3 : CMD_OCW2;
      end
    end
  end
endmodule

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
  import pic_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [DATA_W-1:0] data_i,
  output step_e             step_o,
  output logic              ready_o,
  output logic              err_o,
  output logic [DATA_W-1:0] vec_o,
  output logic              aeoi_o,
  output logic              sfn_o
);
  localparam int PIN_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] VEC_MASK = {{(DATA_W-PIN_W){1'b1}}, {PIN_W{1'b0}}};

  step_e             step_q;
  logic              ready_q, err_q, aeoi_q;
  logic [DATA_W-1:0] vec_q;

  wire icw1_bad = data_i[B_SINGLE] | ~data_i[B_NEED4];
  wire icw4_bad = ~data_i[B_X86];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= STEP_IDLE;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
      vec_q   <= '0;
      aeoi_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (cmd_i)
        CMD_ICW1: begin
          ready_q <= 1'b0;
          err_q   <= icw1_bad;
          step_q  <= icw1_bad ? STEP_IDLE : STEP_ICW2;
        end
        CMD_ICW2: begin
          vec_q  <= data_i & VEC_MASK;
          step_q <= STEP_ICW3;
        end
        CMD_ICW3: step_q <= STEP_ICW4;
        CMD_ICW4: begin
          if (icw4_bad) begin
            err_q <= 1'b1;
          end else begin
            aeoi_q  <= data_i[B_AUTO];
            step_q  <= STEP_IDLE;
            ready_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  generate
    if (IS_MASTER) begin : g_nest
      logic sfn_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              sfn_q <= 1'b0;
        else if (cmd_i == CMD_ICW4 && !icw4_bad) sfn_q <= data_i[B_NEST];
      end
      assign sfn_o = sfn_q;
    end else begin : g_no_nest
      assign sfn_o = 1'b0;
    end
  endgenerate

  assign step_o  = step_q;
  assign ready_o = ready_q;
  assign err_o   = err_q;
  assign vec_o   = vec_q;
  assign aeoi_o  = aeoi_q;

  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |-> step_q == STEP_IDLE);                                          // R8
  AST_ERR_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !ready_q);                                                       // R6
  AST_ERR_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != CMD_ICW1 && cmd_i != CMD_ICW4) |=> !err_q);                      // R3
endmodule

// File: rtl/pic_op_regs.sv
module pic_op_regs
  import pic_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              poll_take_i,
  output logic [DATA_W-1:0] mask_o,
  output logic              smm_o,
  output logic              rsel_o,
  output logic              poll_o
);
  logic [DATA_W-1:0] mask_q;
  logic              smm_q, rsel_q, poll_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      smm_q  <= 1'b0;
      rsel_q <= 1'b0;
      poll_q <= 1'b0;
    end else begin
      if (poll_take_i) poll_q <= 1'b0;
      unique case (cmd_i)
        CMD_ICW1: begin
          mask_q <= '0;
          smm_q  <= 1'b0;
          rsel_q <= 1'b0;
          poll_q <= 1'b0;
        end
        CMD_MASK: mask_q <= data_i;
        CMD_OCW3: begin
          if (data_i[B_SMEN]) smm_q <= data_i[B_SMVAL];
          if (data_i[B_RDREG]) begin
            rsel_q <= data_i[B_RDSVC];
            poll_q <= data_i[B_POLL];
          end
        end
        default: ;
      endcase
    end
  end

  assign mask_o = mask_q;
  assign smm_o  = smm_q;
  assign rsel_o = rsel_q;
  assign poll_o = poll_q;

  AST_POLL_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_take_i |=> !poll_q);                                                  // R12
  AST_SMM_NEEDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != CMD_OCW3 && cmd_i != CMD_ICW1) |=> $stable(smm_q));              // R10
endmodule

// File: rtl/pic_rd_mux.sv
module pic_rd_mux #(
  parameter int DATA_W = 8,
  parameter int PIN_W  = $clog2(DATA_W)
) (
  input  logic              addr_i,
  input  logic              poll_i,
  input  logic              best_valid_i,
  input  logic [PIN_W-1:0]  best_pin_i,
  input  logic              rsel_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] irr_i,
  input  logic [DATA_W-1:0] isr_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (poll_i) begin
      if (best_valid_i) begin
        rdata_o[DATA_W-1]  = 1'b1;
        rdata_o[PIN_W-1:0] = best_pin_i;
      end
    end else if (addr_i) begin
      rdata_o = mask_i;
    end else begin
      rdata_o = rsel_i ? isr_i : irr_i;
    end
  end
endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
  import pic_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter bit IS_MASTER = 1'b1,
  localparam int PIN_W    = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] vec_base_o,
  output logic              aeoi_o,
  output logic              sfn_o,
  output logic              smm_o,
  output logic [DATA_W-1:0] mask_o,
  input  logic [DATA_W-1:0] irr_i,
  input  logic [DATA_W-1:0] isr_i,
  input  logic              best_valid_i,
  input  logic [PIN_W-1:0]  best_pin_i,
  output logic              init_stb_o,
  output logic              ocw2_stb_o,
  output logic [DATA_W-1:0] ocw2_data_o,
  output logic              accept_stb_o,
  output logic [PIN_W-1:0]  accept_pin_o
);
  cmd_e  cmd;
  step_e step;
  logic  rsel, poll, poll_take;

  // write wins; a colliding read has no side effect
  assign poll_take = rd_i & ~wr_i & poll;

  pic_cmd_decode u_dec (
    .wr_i        (wr_i),
    .addr_i      (addr_i),
    .init_bit_i  (wdata_i[B_INIT]),
    .opsel_bit_i (wdata_i[B_OPSEL]),
    .step_i      (step),
    .ready_i     (ready_o),
    .cmd_o       (cmd)
  );

  pic_init_fsm #(.DATA_W(DATA_W), .IS_MASTER(IS_MASTER)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd),
    .data_i  (wdata_i),
    .step_o  (step),
    .ready_o (ready_o),
    .err_o   (err_o),
    .vec_o   (vec_base_o),
    .aeoi_o  (aeoi_o),
    .sfn_o   (sfn_o)
  );

  pic_op_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .data_i      (wdata_i),
    .poll_take_i (poll_take),
    .mask_o      (mask_o),
    .smm_o       (smm_o),
    .rsel_o      (rsel),
    .poll_o      (poll)
  );

  pic_rd_mux #(.DATA_W(DATA_W), .PIN_W(PIN_W)) u_rd (
    .addr_i       (addr_i),
    .poll_i       (poll),
    .best_valid_i (best_valid_i),
    .best_pin_i   (best_pin_i),
    .rsel_i       (rsel),
    .mask_i       (mask_o),
    .irr_i        (irr_i),
    .isr_i        (isr_i),
    .rdata_o      (rdata_o)
  );

  assign init_stb_o   = (cmd == CMD_ICW1);
  assign ocw2_stb_o   = (cmd == CMD_OCW2);
  assign ocw2_data_o  = wdata_i;
  assign accept_stb_o = poll_take & best_valid_i;
  assign accept_pin_o = best_pin_i;

  AST_INIT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_stb_o |=> (!ready_o && mask_o == '0 && !smm_o));                      // R2
  AST_OCW2_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ocw2_stb_o |-> ready_o);                                                   // R9
  AST_ACCEPT_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_stb_o |-> (rdata_o[DATA_W-1] && rdata_o[PIN_W-1:0] == accept_pin_o)); // R12
  AST_VEC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_base_o[PIN_W-1:0] == '0);                                              // R4
endmodule

// File: tb/pic_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module pic_cmd_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_m = 1'b0, wr_s = 1'b0, rd = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] irr = 8'h5A, isr = 8'h24;
  logic       bval = 1'b0;
  logic [2:0] bpin = '0;

  logic [7:0] rdata_m, vec_m, mask_m, ocw2d_m;
  logic       err_m, ready_m, aeoi_m, sfn_m, smm_m, init_m, ocw2_m, acc_m;
  logic [2:0] accpin_m;
  logic [7:0] rdata_s, vec_s, mask_s, ocw2d_s;
  logic       err_s, ready_s, aeoi_s, sfn_s, smm_s, init_s, ocw2_s, acc_s;
  logic [2:0] accpin_s;

  int n_chk = 0, n_fail = 0;
  logic       cap_init, cap_ocw2, r_acc;
  logic [7:0] cap_ocw2d, r_dat;
  logic [2:0] r_pin;

  always #2 clk = ~clk;

  pic_cmd_seq #(.DATA_W(8), .IS_MASTER(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr_m), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_m), .err_o(err_m), .ready_o(ready_m), .vec_base_o(vec_m),
    .aeoi_o(aeoi_m), .sfn_o(sfn_m), .smm_o(smm_m), .mask_o(mask_m),
    .irr_i(irr), .isr_i(isr), .best_valid_i(bval), .best_pin_i(bpin),
    .init_stb_o(init_m), .ocw2_stb_o(ocw2_m), .ocw2_data_o(ocw2d_m),
    .accept_stb_o(acc_m), .accept_pin_o(accpin_m)
  );

  pic_cmd_seq #(.DATA_W(8), .IS_MASTER(1'b0)) dut_s_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr_s), .rd_i(1'b0), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_s), .err_o(err_s), .ready_o(ready_s), .vec_base_o(vec_s),
    .aeoi_o(aeoi_s), .sfn_o(sfn_s), .smm_o(smm_s), .mask_o(mask_s),
    .irr_i(irr), .isr_i(isr), .best_valid_i(bval), .best_pin_i(bpin),
    .init_stb_o(init_s), .ocw2_stb_o(ocw2_s), .ocw2_data_o(ocw2d_s),
    .accept_stb_o(acc_s), .accept_pin_o(accpin_s)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic slv, input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_m = ~slv; wr_s = slv;
    #1;
    cap_init  = slv ? init_s : init_m;
    cap_ocw2  = slv ? ocw2_s : ocw2_m;
    cap_ocw2d = slv ? ocw2d_s : ocw2d_m;
    @(negedge clk);
    wr_m = 1'b0; wr_s = 1'b0;
  endtask

  task automatic do_rd(input logic a);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1;
    r_dat = rdata_m; r_acc = acc_m; r_pin = accpin_m;
    @(negedge clk);
    rd = 1'b0;
  endtask

  typedef struct packed {
    logic       w;
    logic       a;
    logic [7:0] d;
    logic [7:0] e;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 8'h11, 8'h00},  // first word, accepted
    '{1'b1, 1'b1, 8'h25, 8'h00},  // vector base -> 0x20 (R4)
    '{1'b1, 1'b1, 8'h04, 8'h00},  // third word (R5)
    '{1'b1, 1'b1, 8'h01, 8'h00},  // fourth word, 8086 only
    '{1'b1, 1'b1, 8'hB3, 8'h00},  // mask load (R8)
    '{1'b0, 1'b1, 8'h00, 8'hB3},  // read mask R8
    '{1'b0, 1'b0, 8'h00, 8'h5A},  // read request R13
    '{1'b1, 1'b0, 8'h0B, 8'h00},  // select in-service R11
    '{1'b0, 1'b0, 8'h00, 8'h24},  // read in-service R13
    '{1'b1, 1'b0, 8'h0A, 8'h00},  // select request R11
    '{1'b0, 1'b0, 8'h00, 8'h5A},  // read request R13
    '{1'b1, 1'b1, 8'h00, 8'h00},  // clear mask
    '{1'b0, 1'b1, 8'h00, 8'h00}   // read mask R8
  };

  initial begin : watchdog
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {7'd0, ready_m}, 8'h00);
    chk("R1 vec", vec_m, 8'h00);
    chk("R1 mask", mask_m, 8'h00);
    chk("R1 flags", {3'd0, aeoi_m, sfn_m, smm_m, err_m, ready_s}, 8'h00);
    do_rd(1'b0);
    chk("R1 read selects request", r_dat, 8'h5A);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].w) begin
        do_wr(1'b0, TBL[i].a, TBL[i].d);
      end else begin
        do_rd(TBL[i].a);
        chk($sformatf("R13/R8 table row %0d", i), r_dat, TBL[i].e);
      end
    end
    chk("R8 ready", {7'd0, ready_m}, 8'h01);
    chk("R4 vec base", vec_m, 8'h20);
    chk("R7 aeoi/sfn off", {6'd0, aeoi_m, sfn_m}, 8'h00);

    // R9 end-of-interrupt command strobe
    do_wr(1'b0, 1'b0, 8'h60);
    chk("R9 ocw2 strobe", {7'd0, cap_ocw2}, 8'h01);
    chk("R9 ocw2 data", cap_ocw2d, 8'h60);
    chk("R9 no init strobe", {7'd0, cap_init}, 8'h00);

    // R10 special mask mode
    do_wr(1'b0, 1'b0, 8'h68);
    chk("R10 smm set", {7'd0, smm_m}, 8'h01);
    do_wr(1'b0, 1'b0, 8'h28);
    chk("R10 smm kept without enable", {7'd0, smm_m}, 8'h01);
    do_wr(1'b0, 1'b0, 8'h48);
    chk("R10 smm cleared", {7'd0, smm_m}, 8'h00);

    // R11 select held without read-register bit
    do_wr(1'b0, 1'b0, 8'h09);
    do_rd(1'b0);
    chk("R11 select unchanged", r_dat, 8'h5A);

    // R12 poll
    do_wr(1'b0, 1'b1, 8'h3C);
    do_wr(1'b0, 1'b0, 8'h0E);
    bval = 1'b1; bpin = 3'd5;
    do_rd(1'b1);
    chk("R12 poll byte", r_dat, 8'h85);
    chk("R12 accept strobe", {4'd0, r_acc, r_pin}, 8'h0D);
    do_rd(1'b1);
    chk("R12 poll consumed", r_dat, 8'h3C);
    chk("R12 no second accept", {7'd0, r_acc}, 8'h00);
    do_wr(1'b0, 1'b0, 8'h0E);
    bval = 1'b0;
    do_rd(1'b0);
    chk("R12 poll empty", r_dat, 8'h00);
    chk("R12 empty no accept", {7'd0, r_acc}, 8'h00);
    do_rd(1'b0);
    chk("R12 empty poll consumed", r_dat, 8'h5A);
    do_wr(1'b0, 1'b0, 8'h0C);
    do_rd(1'b1);
    chk("R11 poll not latched without read bit", r_dat, 8'h3C);

    // R2 restart while running
    do_wr(1'b0, 1'b1, 8'h77);
    do_wr(1'b0, 1'b0, 8'h68);
    do_wr(1'b0, 1'b0, 8'h0B);
    do_wr(1'b0, 1'b0, 8'h11);
    chk("R2 init strobe", {7'd0, cap_init}, 8'h01);
    chk("R2 state cleared", {mask_m[6:0], smm_m}, 8'h00);
    chk("R2 ready dropped", {7'd0, ready_m}, 8'h00);
    do_rd(1'b0);
    chk("R2 select cleared", r_dat, 8'h5A);
    do_wr(1'b0, 1'b0, 8'h60);
    chk("R9 ignored when not ready", {6'd0, cap_ocw2, smm_m}, 8'h00);
    do_wr(1'b0, 1'b1, 8'h4F);
    chk("R4 vec base masked", vec_m, 8'h48);
    do_wr(1'b0, 1'b1, 8'hFF);
    chk("R5 third word discarded", mask_m, 8'h00);
    chk("R5 vec kept", vec_m, 8'h48);
    do_wr(1'b0, 1'b1, 8'h02);
    chk("R6 bad fourth word err", {6'd0, err_m, ready_m}, 8'h02);
    do_wr(1'b0, 1'b1, 8'h13);
    chk("R6 retry accepted", {6'd0, err_m, ready_m}, 8'h01);
    chk("R7 aeoi/sfn master", {6'd0, aeoi_m, sfn_m}, 8'h03);
    chk("R8 mask untouched by fourth word", mask_m, 8'h00);

    // R3 rejected first word
    do_wr(1'b0, 1'b0, 8'h13);
    chk("R3 single rejected", {6'd0, err_m, ready_m}, 8'h02);
    @(negedge clk);
    chk("R3 err one cycle", {7'd0, err_m}, 8'h00);
    do_wr(1'b0, 1'b1, 8'h99);
    chk("R3 odd write loads mask", mask_m, 8'h99);
    chk("R3 vec kept", vec_m, 8'h48);
    do_wr(1'b0, 1'b0, 8'h10);
    chk("R3 missing fourth rejected", {6'd0, err_m, ready_m}, 8'h02);

    // R7 slave ignores fully-nested
    do_wr(1'b1, 1'b0, 8'h11);
    do_wr(1'b1, 1'b1, 8'h70);
    do_wr(1'b1, 1'b1, 8'h02);
    do_wr(1'b1, 1'b1, 8'h13);
    chk("R7 slave ready/aeoi/sfn", {5'd0, ready_s, aeoi_s, sfn_s}, 8'h06);
    chk("R4 slave vec", vec_s, 8'h70);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule